// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Controller

This block sits beside a CPU core and owns its interrupt inputs. It accepts a maskable request level, a non-maskable request line and an external synchronisation pin. At every instruction boundary reported by the core it decides whether to enter an interrupt. A non-maskable request is reported at once with a fixed vector type. A maskable request first runs a two-pulse acknowledge handshake on the bus. The vector type is then taken from the low data byte, and the result is handed to the core as a one-cycle take strobe with the type alongside.

The block also gates the core's wait-for-synchronisation instruction. While the core asserts its wait command and the synchronisation pin is high, the stall output holds the core. Fetching the vector table entry belongs to the core, not to this block.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ack_n_o` is 1, `vec_take_o` is 0 and `stall_o` is 0 whenever `wait_cmd_i` is 0.
- R2: `stall_o` is 1 in exactly those cycles where both `wait_cmd_i` and `sync_pin_i` are 1. It is combinational and has no cycle of delay.
- R3: `mask_irq_i` is acted on only at a clock edge where `boundary_i` is 1, the controller is idle, `irq_en_i` is 1 and no non-maskable request is pending. At any other edge it starts no acknowledge pulse.
- R4: An accepted maskable request drives `ack_n_o` low for BUS_CLKS cycles, starting in the cycle right after the boundary edge. `ack_n_o` then goes high for GAP_CLKS cycles, then low again for BUS_CLKS cycles (defaults 4, 2, 4).
- R5: The vector type is `bus_data_i` as sampled at the edge that ends the second low pulse. In the cycle after that edge, `vec_take_o` is 1 for exactly one cycle and `vec_type_o` carries the captured byte.
- R6: A 0-to-1 change of `nomask_irq_i` is latched. At the next idle boundary edge the request is taken: `vec_take_o` is 1 in the following cycle with `vec_type_o` = 2 (NMI_TYPE), and no acknowledge pulse is issued.
- R7: When a non-maskable request is pending at a boundary edge and a maskable request is also valid, only the non-maskable one is taken at that edge.
- R8: One rising change of `nomask_irq_i` gives exactly one service. Holding the line high gives no further service. A line already high when reset is released counts as no change.
- R9: `irq_en_i` has no effect on non-maskable requests.
- R10: Boundary strobes that come while an acknowledge handshake or a report is in progress are ignored. A non-maskable change seen during a handshake stays latched and is taken at the first boundary after the controller is idle again.
- R11: A rising change of `nomask_irq_i` sampled at the same edge that takes a pending non-maskable request stays latched, and it gives a second service at a later boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | High in the final clock of each instruction |
| irq_en_i | input | 1 | Core interrupt-enable flag |
| mask_irq_i | input | 1 | Maskable request level |
| nomask_irq_i | input | 1 | Non-maskable request, edge sensitive |
| sync_pin_i | input | 1 | External synchronisation pin |
| wait_cmd_i | input | 1 | Core is executing wait-for-synchronisation |
| bus_data_i | input | 8 | Low data byte, carries the vector type |
| ack_n_o | output | 1 | Acknowledge strobe, active low |
| vec_take_o | output | 1 | One-cycle strobe: enter interrupt |
| vec_type_o | output | 8 | Vector type, valid with vec_take_o |
| stall_o | output | 1 | Holds the core during wait-for-synchronisation |

## Verification
Two functions can meet at a single edge. One is the service of a latched non-maskable request, which clears the latch. The other is a fresh rising change on the same line, which sets it. The bench provokes this by letting the line fall after a first change and then raising it in the very cycle it presents the boundary strobe that takes the first request. It passes only if a second type-2 service follows at a later boundary and the cycle-by-cycle model agrees on every output. A second meeting point, a latched non-maskable request and a valid maskable level at one boundary, is judged by checking that no acknowledge pulse appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_ACK1   = 3'd1,
    SEQ_GAP    = 3'd2,
    SEQ_ACK2   = 3'd3,
    SEQ_REPORT = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic line_q, line_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = line_i & ~line_q;
    line_d = line_i;
    // a new edge wins over the clear of the request being served
    if (rise)       pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int BUS_CLKS = 4,
  parameter int GAP_CLKS = 2,
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ack_i,
  input  logic              start_nmi_i,
  input  logic [TYPE_W-1:0] data_i,
  output logic              ack_n_o,
  output logic              take_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              idle_o
);
  localparam int MAXC  = (BUS_CLKS > GAP_CLKS) ? BUS_CLKS : GAP_CLKS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] BUS_LAST = CNT_W'(BUS_CLKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TYPE_W-1:0] type_q, type_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    type_d  = type_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_nmi_i) begin
          state_d = SEQ_REPORT;
          type_d  = TYPE_W'(NMI_TYPE);
        end else if (start_ack_i) begin
          state_d = SEQ_ACK1;
          cnt_d   = '0;
        end
      end
      SEQ_ACK1: begin
        if (cnt_q == BUS_LAST) begin
          state_d = SEQ_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = SEQ_ACK2;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_ACK2: begin
        if (cnt_q == BUS_LAST) begin
          state_d = SEQ_REPORT;
          cnt_d   = '0;
          type_d  = data_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_REPORT: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      type_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      type_q  <= type_d;
    end
  end

  assign ack_n_o = ~((state_q == SEQ_ACK1) | (state_q == SEQ_ACK2));
  assign take_o  = (state_q == SEQ_REPORT);
  assign idle_o  = (state_q == SEQ_IDLE);
  assign type_o  = type_q;
endmodule

// File: rtl/irq_stall_gate.sv
module irq_stall_gate (
  input  logic wait_cmd_i,
  input  logic sync_pin_i,
  output logic stall_o
);
  always_comb stall_o = wait_cmd_i & sync_pin_i;
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int BUS_CLKS = 4,
  parameter int GAP_CLKS = 2,
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              irq_en_i,
  input  logic              mask_irq_i,
  input  logic              nomask_irq_i,
  input  logic              sync_pin_i,
  input  logic              wait_cmd_i,
  input  logic [TYPE_W-1:0] bus_data_i,
  output logic              ack_n_o,
  output logic              vec_take_o,
  output logic [TYPE_W-1:0] vec_type_o,
  output logic              stall_o
);
  logic nmi_pend;
  logic seq_idle;
  logic accept, take_nmi, start_ack;

  always_comb begin
    accept    = boundary_i & seq_idle;
    take_nmi  = accept & nmi_pend;
    start_ack = accept & ~nmi_pend & mask_irq_i & irq_en_i;
  end

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (nomask_irq_i),
    .clr_i  (take_nmi),
    .pend_o (nmi_pend)
  );

  irq_ack_seq #(
    .BUS_CLKS (BUS_CLKS),
    .GAP_CLKS (GAP_CLKS),
    .TYPE_W   (TYPE_W),
    .NMI_TYPE (NMI_TYPE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ack_i (start_ack),
    .start_nmi_i (take_nmi),
    .data_i      (bus_data_i),
    .ack_n_o     (ack_n_o),
    .take_o      (vec_take_o),
    .type_o      (vec_type_o),
    .idle_o      (seq_idle)
  );

  irq_stall_gate u_stall (
    .wait_cmd_i (wait_cmd_i),
    .sync_pin_i (sync_pin_i),
    .stall_o    (stall_o)
  );
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
  parameter int BUS_CLKS = 4,
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wait_cmd_i,
  input logic              sync_pin_i,
  input logic [TYPE_W-1:0] bus_data_i,
  input logic              ack_n_o,
  input logic              vec_take_o,
  input logic [TYPE_W-1:0] vec_type_o,
  input logic              stall_o
);
  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (ack_n_o)  low_run_q <= '0;
    else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 1'b1;
  end

  // R4
  ack_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n_o) |-> (low_run_q == 16'(BUS_CLKS)));

  // R5
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |=> !vec_take_o);

  // R5
  type_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take_o && !$past(ack_n_o)) |-> (vec_type_o == $past(bus_data_i)));

  // R6
  nmi_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take_o && $past(ack_n_o)) |-> (vec_type_o == TYPE_W'(NMI_TYPE)));

  // R2
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_cmd_i && sync_pin_i) |-> !stall_o);

  // R5
  take_ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |-> ack_n_o);
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
  .BUS_CLKS (BUS_CLKS),
  .TYPE_W   (TYPE_W),
  .NMI_TYPE (NMI_TYPE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wait_cmd_i (wait_cmd_i),
  .sync_pin_i (sync_pin_i),
  .bus_data_i (bus_data_i),
  .ack_n_o    (ack_n_o),
  .vec_take_o (vec_take_o),
  .vec_type_o (vec_type_o),
  .stall_o    (stall_o)
);

// File: tb/irq_ack_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb;
  localparam int B = 4;
  localparam int G = 2;
  localparam int L = 2*B + G + 1;
  localparam logic [7:0] NMI_T = 8'd2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bnd, en, irq, nmi, tst, wt;
  logic [7:0] dat;
  logic ack_n, take, stall;
  logic [7:0] vtype;

  irq_ack_ctrl #(.BUS_CLKS(B), .GAP_CLKS(G), .TYPE_W(8), .NMI_TYPE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(bnd), .irq_en_i(en),
    .mask_irq_i(irq), .nomask_irq_i(nmi), .sync_pin_i(tst),
    .wait_cmd_i(wt), .bus_data_i(dat), .ack_n_o(ack_n),
    .vec_take_o(take), .vec_type_o(vtype), .stall_o(stall));

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";
  int take_cnt = 0;
  int low_cnt = 0;

  // reference model state, advanced at each rising edge
  int m_pos;
  bit m_nrep, m_pend, m_prev, m_edge, m_idle, m_tn;
  logic [7:0] m_type;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_nrep = 0; m_pend = 0; m_prev = 1; m_type = 8'h00;
    end else begin
      m_edge = nmi && !m_prev;
      m_idle = (m_pos == 0) && !m_nrep;
      m_tn   = 0;
      m_prev = nmi;
      if (m_nrep) m_nrep = 0;
      else if (m_pos > 0) begin
        if (m_pos == 2*B + G) m_type = dat;
        m_pos = (m_pos == L) ? 0 : m_pos + 1;
      end
      if (m_idle && bnd) begin
        if (m_pend) begin m_tn = 1; m_nrep = 1; m_type = NMI_T; end
        else if (irq && en) m_pos = 1;
      end
      if (m_edge) m_pend = 1;
      else if (m_tn) m_pend = 0;
    end
  end

  function automatic bit exp_ack_n();
    return !((m_pos >= 1 && m_pos <= B) || (m_pos >= B+G+1 && m_pos <= 2*B+G));
  endfunction
  function automatic bit exp_take();
    return m_nrep || (m_pos == L);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d t=%0t", req, cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(ack_n == exp_ack_n(), "R4", "ack_n_o", ack_n, exp_ack_n());
    check(take == exp_take(), "R5", "vec_take_o", take, exp_take());
    if (exp_take()) check(vtype == m_type, "R5", "vec_type_o", vtype, m_type);
    check(stall == (wt && tst), "R2", "stall_o", stall, wt && tst);
    if (take) take_cnt++;
    if (!ack_n) low_cnt++;
  endtask

  task automatic step(input bit b, input bit e, input bit i, input bit n,
                      input bit t, input bit w, input logic [7:0] d);
    @(negedge clk);
    compare();
    bnd = b; en = e; irq = i; nmi = n; tst = t; wt = w; dat = d;
  endtask

  task automatic idle_steps(input int k, input bit n);
    for (int j = 0; j < k; j++) step(0, 1, 0, n, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F3A_5C07));
    rst_n = 0; bnd = 0; en = 0; irq = 0; nmi = 1; tst = 0; wt = 0; dat = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(ack_n == 1'b1, "R1", "ack_n_o in reset", ack_n, 1);
    check(take == 1'b0, "R1", "vec_take_o in reset", take, 0);
    check(stall == 1'b0, "R1", "stall_o in reset", stall, 0);
    rst_n = 1;
    // R8: line high at reset release is not an edge
    cur_req = "R8"; take_cnt = 0;
    idle_steps(2, 1);
    step(1, 1, 0, 1, 0, 0, 8'h00);
    idle_steps(3, 0);
    check(take_cnt == 0, "R8", "takes after high-at-reset", take_cnt, 0);

    cur_req = "R2";
    step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 1, 0);
    idle_steps(2, 0);

    // R3: masked request and request without boundary
    cur_req = "R3"; low_cnt = 0;
    step(1, 0, 1, 0, 0, 0, 8'h55);
    for (int j = 0; j < 6; j++) step(0, 1, 1, 0, 0, 0, 8'h55);
    idle_steps(L + 2, 0);
    check(low_cnt == 0, "R3", "ack low cycles while masked", low_cnt, 0);

    // R4 / R5: full handshake, data changes each cycle
    cur_req = "R5"; take_cnt = 0; low_cnt = 0;
    step(1, 1, 1, 0, 0, 0, 8'h00);
    for (int j = 0; j < L + 3; j++) step(0, 1, 0, 0, 0, 0, 8'(8'hA0 + j));
    check(take_cnt == 1, "R5", "takes per handshake", take_cnt, 1);
    check(low_cnt == 2*B, "R4", "ack low cycles", low_cnt, 2*B);

    // R6 / R9: edge with enable clear
    cur_req = "R9"; take_cnt = 0; low_cnt = 0;
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0); idle_steps(3, 1);
    check(take_cnt == 1, "R6", "non-maskable takes", take_cnt, 1);
    check(low_cnt == 0, "R6", "ack low on non-maskable", low_cnt, 0);

    // R8: held high over many boundaries
    cur_req = "R8"; take_cnt = 0;
    for (int j = 0; j < 6; j++) begin step(1, 1, 0, 1, 0, 0, 0); step(0, 1, 0, 1, 0, 0, 0); end
    check(take_cnt == 0, "R8", "takes while held", take_cnt, 0);
    idle_steps(2, 0);

    // R7: both at one boundary
    cur_req = "R7"; low_cnt = 0; take_cnt = 0;
    step(0, 1, 1, 1, 0, 0, 0); step(0, 1, 1, 1, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0, 8'h77); step(0, 1, 0, 1, 0, 0, 0); idle_steps(2, 1);
    check(low_cnt == 0, "R7", "ack low with both pending", low_cnt, 0);
    check(take_cnt == 1, "R7", "takes with both pending", take_cnt, 1);
    idle_steps(2, 0);

    // R10: boundaries and an edge during a handshake
    cur_req = "R10"; take_cnt = 0;
    step(1, 1, 1, 0, 0, 0, 8'h3C);
    for (int j = 0; j < L; j++) step(1, 1, 1, (j >= 3), 0, 0, 8'h3C);
    step(0, 1, 0, 1, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0, 0); idle_steps(3, 1);
    check(take_cnt == 2, "R10", "takes handshake then held edge", take_cnt, 2);
    idle_steps(2, 0);

    // R11: edge in the same cycle as the non-maskable take
    cur_req = "R11"; take_cnt = 0;
    step(0, 1, 0, 1, 0, 0, 0); step(0, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 1, 0, 0, 0);
    idle_steps(3, 1);
    step(1, 1, 0, 1, 0, 0, 0); idle_steps(3, 1);
    check(take_cnt == 2, "R11", "takes after coincident edge", take_cnt, 2);
    idle_steps(2, 0);

    // random mix, all outputs compared with the model each cycle
    cur_req = "random";
    for (int j = 0; j < 4000; j++) begin
      logic nn;
      nn = (($urandom % 8) == 0) ? ~nmi : nmi;
      step(($urandom % 4) == 0, ($urandom % 4) != 0, $urandom % 2, nn,
           $urandom % 2, ($urandom % 3) == 0, 8'($urandom));
    end
    idle_steps(L + 2, 0);
    finish_run();
  end
endmodule